// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the bytes of a received Ethernet frame as they arrive and decides whether the frame carries a wake-up pattern addressed to this station. The pattern is a run of at least six bytes equal to 0xFF, followed at once by the station's 48-bit address sent sixteen times back to back. The pattern may sit anywhere after the frame's two address fields; the frame's trailing CRC is checked outside this block, and the result arrives as a frame-good flag alongside the last byte.

Detection is gated by the power state. In the full-power state, a software enable bit turns detection on. In the low-power state, detection is on whatever that bit says. In every other state the block never wakes. When a good frame that holds the pattern ends, the block raises a one-cycle wake pulse and sets a sticky status flag. Software clears that flag by writing a one.

Top module: `magic_wake_detect`

## Requirements
- R1: A frame that holds six 0xFF bytes followed by sixteen back-to-back copies of the station address, and that ends with frame_good high, raises wake_pulse in the cycle after the clock edge that accepts its end-of-frame byte.
- R2: Each address copy is compared most significant byte first: station_addr[47:40] is expected first and station_addr[7:0] last. A copy in any other byte order does not match.
- R3: The first 12 bytes of a frame (the two address fields, counted from the start-of-frame byte) are never used for matching, even when they contain pattern bytes.
- R4: A run of more than six 0xFF bytes is a valid synchronisation run. Address comparison starts with the first byte after the last 0xFF.
- R5: A byte that fails to match inside the address copies restarts the search. If that byte is 0xFF, it counts as the first byte of a new synchronisation run.
- R6: A frame whose frame_good is low on its end-of-frame byte never raises wake_pulse, even when it holds the full pattern.
- R7: pwr_state is encoded as 0 = full power, 1 = low power, 2 and 3 = other states. With 0, a wake needs mp_enable high. With 1, a wake needs no enable. With 2 or 3, there is never a wake.
- R8: wake_status goes high together with wake_pulse and stays high until sts_clear is sampled high. If a clear and a new wake fall in the same cycle, the flag stays set.
- R9: Every start-of-frame byte resets the matcher. A partial pattern from an earlier frame, including one that was cut off without an end-of-frame byte, never counts toward a later frame.
- R10: wake_pulse is one cycle wide and appears only in the cycle that follows an accepted end-of-frame byte.
- R11: Fewer than six 0xFF bytes, or fewer than sixteen address copies, is not a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | The current byte is the first byte of a frame |
| rx_eof | input | 1 | The current byte is the last byte of a frame |
| frame_good | input | 1 | The CRC check passed; sampled with the end-of-frame byte |
| station_addr | input | 48 | The station's own address |
| mp_enable | input | 1 | Detection enable used in the full-power state |
| pwr_state | input | 2 | Power state: 0 full power, 1 low power, 2/3 other |
| sts_clear | input | 1 | Write-one-to-clear strobe for wake_status |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_status | output | 1 | Sticky wake flag |

## Verification
The in-module assertions check the following on every cycle:
- wake_pulse is a single cycle wide.
- wake_pulse follows only an end-of-frame byte that had frame_good high and an armed power state.
- wake_status is set whenever wake_pulse is, holds until a clear, and drops after a clear unless a new wake arrives.
- The synchronisation counter stays within its range.

Other behaviours are content-dependent and only the bench scenarios can show them:
- matching the address in the right byte order;
- skipping the header;
- restarting on a mismatched 0xFF byte;
- discarding a cut-off frame's partial match.

The bench checks these against a window search that looks for the complete pattern at any offset past the header.

// File: rtl/magic_wake_detect.sv
module magic_wake_detect #(
  parameter int SYNC_LEN = 6,
  parameter int REPEATS  = 16,
  parameter int HDR_LEN  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        frame_good,
  input  logic [47:0] station_addr,
  input  logic        mp_enable,
  input  logic [1:0]  pwr_state,
  input  logic        sts_clear,
  output logic        wake_pulse,
  output logic        wake_status
);
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam int HW = $clog2(HDR_LEN + 1);
  localparam logic [1:0] PS_FULL = 2'd0;
  localparam logic [1:0] PS_LOW  = 2'd1;

  logic [HW-1:0] hdr_q, c_hdr, n_hdr;
  logic [SW-1:0] sync_q, c_sync, n_sync;
  logic [2:0]    idx_q, c_idx, n_idx;
  logic [RW-1:0] rep_q, c_rep, n_rep;
  logic          found_q, c_found, n_found;
  logic          in_frame_q, take, armed, is_ff, wake_set;
  logic [7:0]    exp_byte;

  assign take     = rx_valid && (rx_sof || in_frame_q);
  assign armed    = (pwr_state == PS_FULL && mp_enable) || pwr_state == PS_LOW;
  assign is_ff    = rx_data == 8'hFF;
  assign exp_byte = station_addr[8*(5 - int'(c_idx)) +: 8];
  assign wake_set = take && rx_eof && n_found && frame_good && armed;

  always_comb begin
    c_hdr   = rx_sof ? '0 : hdr_q;
    c_sync  = rx_sof ? '0 : sync_q;
    c_idx   = rx_sof ? '0 : idx_q;
    c_rep   = rx_sof ? '0 : rep_q;
    c_found = rx_sof ? 1'b0 : found_q;
    n_hdr   = c_hdr;
    n_sync  = c_sync;
    n_idx   = c_idx;
    n_rep   = c_rep;
    n_found = c_found;
    if (c_hdr != HW'(HDR_LEN)) begin
      n_hdr = c_hdr + HW'(1);
    end else if (armed && !c_found) begin
      if (c_sync != SW'(SYNC_LEN)) begin
        n_sync = is_ff ? c_sync + SW'(1) : '0;
      end else if (c_idx == 3'd0 && c_rep == '0 && is_ff) begin
        n_sync = c_sync;
      end else if (rx_data == exp_byte) begin
        if (c_idx == 3'd5) begin
          n_idx = '0;
          if (c_rep == RW'(REPEATS - 1)) n_found = 1'b1;
          else n_rep = c_rep + RW'(1);
        end else begin
          n_idx = c_idx + 3'd1;
        end
      end else begin
        n_sync = is_ff ? SW'(1) : '0;
        n_idx  = '0;
        n_rep  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q       <= '0;
      sync_q      <= '0;
      idx_q       <= '0;
      rep_q       <= '0;
      found_q     <= 1'b0;
      in_frame_q  <= 1'b0;
      wake_pulse  <= 1'b0;
      wake_status <= 1'b0;
    end else begin
      if (take) begin
        hdr_q      <= n_hdr;
        sync_q     <= n_sync;
        idx_q      <= n_idx;
        rep_q      <= n_rep;
        found_q    <= n_found;
        in_frame_q <= !rx_eof;
      end
      wake_pulse <= wake_set;
      if (wake_set) wake_status <= 1'b1;
      else if (sts_clear) wake_status <= 1'b0;
    end
  end

  p_pulse_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(rx_valid && rx_eof));
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  p_good_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(frame_good));
  p_power_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(pwr_state == 2'd1 || (pwr_state == 2'd0 && mp_enable)));
  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_status);
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_status && !sts_clear |=> wake_status);
  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clear |=> (!wake_status || wake_pulse));
  p_sync_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q <= SW'(SYNC_LEN));
endmodule

// File: tb/magic_wake_detect_tb.sv
module magic_wake_detect_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, rx_valid, rx_sof, rx_eof, frame_good, mp_enable, sts_clear;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic [1:0]  pwr_state;
  logic        wake_pulse, wake_status;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_stat = 0;
  logic [7:0] fr[$];

  magic_wake_detect dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .frame_good(frame_good),
    .station_addr(station_addr), .mp_enable(mp_enable), .pwr_state(pwr_state),
    .sts_clear(sts_clear), .wake_pulse(wake_pulse), .wake_status(wake_status));

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit has_pattern(logic [47:0] a);
    for (int p = 12; p + 102 <= fr.size(); p++) begin
      bit ok = 1;
      for (int k = 0; k < 6; k++) if (fr[p+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (fr[p+6+k] != a[47-8*(k%6) -: 8]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  function automatic bit armed_model();
    return (pwr_state == 2'd0 && mp_enable) || pwr_state == 2'd1;
  endfunction

  task automatic add_ff(int n);
    repeat (n) fr.push_back(8'hFF);
  endtask

  task automatic add_addr(int reps, logic [47:0] a);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 6; k++) fr.push_back(a[47-8*k -: 8]);
  endtask

  task automatic add_rand(int n);
    repeat (n) fr.push_back(8'($urandom % 255));
  endtask

  task automatic new_frame();
    fr.delete();
    add_rand(12);
  endtask

  task automatic send_frame(bit good, bit do_eof, bit gaps, bit clr_eof, string req);
    bit expp = do_eof && good && armed_model() && has_pattern(station_addr);
    bit spurious = 0;
    for (int i = 0; i < fr.size(); i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        if (wake_pulse) spurious = 1;
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
      end
      @(negedge clk);
      if (wake_pulse) spurious = 1;
      rx_valid   = 1;
      rx_data    = fr[i];
      rx_sof     = (i == 0);
      rx_eof     = do_eof && (i == fr.size() - 1);
      frame_good = good;
      sts_clear  = clr_eof && rx_eof;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; sts_clear = 0;
    check(wake_pulse == expp, req, "wake_pulse at end of frame", wake_pulse, expp);
    check(!spurious, "R10", "no pulse before end of frame", spurious, 0);
    @(negedge clk);
    check(wake_pulse == 0, "R10", "pulse one cycle wide", wake_pulse, 0);
    if (expp) exp_stat = 1;
    else if (clr_eof) exp_stat = 0;
    check(wake_status == exp_stat, "R8", "wake_status after frame", wake_status, exp_stat);
    fr.delete();
  endtask

  task automatic do_clear();
    @(negedge clk) sts_clear = 1;
    @(negedge clk) sts_clear = 0;
    exp_stat = 0;
    check(wake_status == 0, "R8", "wake_status after clear", wake_status, 0);
  endtask

  task automatic set_pwr(logic [1:0] ps, logic en);
    pwr_state = ps;
    mp_enable = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; rx_valid = 0; rx_data = 0; rx_sof = 0; rx_eof = 0; frame_good = 0;
    sts_clear = 0;
    station_addr = 48'h02A1_B2C3_D4E5;
    set_pwr(2'd0, 1);
    repeat (3) @(negedge clk);
    check(wake_pulse == 0, "R10", "reset pulse", wake_pulse, 0);
    check(wake_status == 0, "R8", "reset status", wake_status, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2: basic pattern, full power with enable
    new_frame(); add_rand(5); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R1");
    do_clear();
    // R2: reversed byte order
    new_frame(); add_ff(6); add_addr(16, {station_addr[7:0], station_addr[15:8], station_addr[23:16],
      station_addr[31:24], station_addr[39:32], station_addr[47:40]}); add_rand(4);
    send_frame(1, 1, 0, 0, "R2");
    // R3: pattern starting inside the header
    fr.delete(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R3");
    // R4: longer synchronisation run
    new_frame(); add_ff(9); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 1, 0, "R4");
    do_clear();
    // R5: mismatch byte 0xFF begins a new run
    new_frame(); add_ff(6); add_addr(7, station_addr); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R5");
    do_clear();
    // R6: bad CRC
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(0, 1, 0, 0, "R6");
    // R7: power gating
    set_pwr(2'd0, 0);
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R7");
    set_pwr(2'd1, 0);
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R7");
    do_clear();
    set_pwr(2'd2, 1);
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R7");
    set_pwr(2'd3, 1);
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R7");
    set_pwr(2'd0, 1);
    // R11: too few repeats, too short a run
    new_frame(); add_ff(6); add_addr(15, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R11");
    new_frame(); add_rand(1); add_ff(5); add_addr(16, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R11");
    // R9: cut-off frame, then the remainder in a new frame
    new_frame(); add_ff(6); add_addr(10, station_addr);
    send_frame(1, 0, 0, 0, "R9");
    fr.delete(); add_addr(2, station_addr); add_addr(6, station_addr); add_rand(4);
    send_frame(1, 1, 0, 0, "R9");
    // R8: clear in the same cycle as a new wake, then after
    new_frame(); add_ff(6); add_addr(16, station_addr); add_rand(2);
    send_frame(1, 1, 0, 1, "R8");
    do_clear();

    // random frames
    for (int n = 0; n < 250; n++) begin
      int segs = 1 + $urandom % 4;
      set_pwr(2'($urandom % 4), 1'($urandom % 2));
      new_frame();
      for (int s = 0; s < segs; s++) begin
        case ($urandom % 5)
          0: add_rand(1 + $urandom % 10);
          1: add_ff(1 + $urandom % 8);
          2: add_addr(1 + $urandom % 16, station_addr);
          3: begin add_ff(6 + $urandom % 3); add_addr(16, station_addr); end
          default: begin add_ff(6); add_addr(10 + $urandom % 7, station_addr); end
        endcase
      end
      add_rand(4);
      send_frame($urandom % 4 != 0, 1, $urandom % 2, 0, "R1");
      if ($urandom % 6 == 0) do_clear();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule